// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block folds a wide vector of level-sensitive interrupt sources into a small set of group lines for a parent interrupt controller. Sources come in groups of eight. Each group has its own output line, and that line is high while any enabled source of the group is high. Software masks or unmasks single sources through enable bits. It sees which enabled sources are active through a status word.

Four neighbouring groups share one 32-bit register bank, one byte lane per group. Enables are changed only through two write addresses. One address sets the bits written as 1, the other clears the bits written as 1. A read-modify-write is therefore never needed, and a write to one group cannot disturb the other groups of its bank. The sources are synchronised to the block clock before they are masked, and the group lines leave the block from flip-flops.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0 and rdata_o is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write data bit is 1 and leaves every other enable bit unchanged.
- R3: A write to bank offset 0x4 clears each enable bit whose write data bit is 1 and leaves every other enable bit unchanged.
- R4: A read of bank offset 0x0 or 0x4 returns the 32 enable bits of that bank.
- R5: A read of bank offset 0xC returns the bank status word. Bank b is selected by address bits [7:4] equal to b, which is offset b*0x10. Group g lives in bank g/4 at bits [8*(g%4)+7 : 8*(g%4)]. Source number s = 8*g + line. A status bit is 1 when its synchronised source is high and its enable bit is 1.
- R6: Group output g is the OR of the eight status bits of group g. It follows a source change on the third rising edge after the change and an enable write on the first rising edge after the write edge.
- R7: A write to offset 0xC, to offset 0x8, to any other offset, or to a bank at or beyond NUM_GROUPS/4 (rounded up) changes no enable bit. A read of such an address returns 0.
- R8: rdata_o is registered. It carries the read result in the cycle after rd_en_i is sampled high and is 0 after a cycle with rd_en_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_GROUPS*8 | Level interrupt sources, bit 8*g+line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address: [ADDR_W-1:4] bank, [3:0] offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| group_irq_o | output | NUM_GROUPS | One level output per group |

## Verification
On every cycle the assertions check several things. A set write makes its bits 1 and a clear write makes its bits 0. Enables stay unchanged with no valid write and after ignored writes. The synchronised sources lag the inputs by exactly two edges. A group output never rises without an enabled and active source in the preceding cycle. Unmapped reads return zero. Other properties only the bench scenarios can show: that the byte-lane placement and bank addressing match the source numbering, the full status word value under random source and enable patterns, and the exact three-edge source-to-output latency.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned LINES_PER_GROUP = 8;
  localparam int unsigned GROUPS_PER_BANK = 4;
  localparam int unsigned BANK_DW         = LINES_PER_GROUP * GROUPS_PER_BANK;

  localparam logic [3:0] OFS_SET  = 4'h0;
  localparam logic [3:0] OFS_CLR  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  function automatic int unsigned bank_of(input int unsigned grp);
    return grp / GROUPS_PER_BANK;
  endfunction

  function automatic int unsigned lane_of(input int unsigned grp);
    return grp % GROUPS_PER_BANK;
  endfunction

  function automatic int unsigned src_index(input int unsigned grp, input int unsigned line);
    return grp * LINES_PER_GROUP + line;
  endfunction

  function automatic int unsigned banks_for(input int unsigned groups);
    return (groups + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
  endfunction

  function automatic int unsigned lanes_in_bank(input int unsigned groups, input int unsigned bank);
    int unsigned left;
    left = groups - bank * GROUPS_PER_BANK;
    return (left >= GROUPS_PER_BANK) ? GROUPS_PER_BANK : left;
  endfunction

  function automatic logic [BANK_DW-1:0] lane_mask(input int unsigned lanes);
    logic [BANK_DW-1:0] m;
    m = '0;
    for (int unsigned l = 0; l < GROUPS_PER_BANK; l++) begin
      if (l < lanes) m[l*LINES_PER_GROUP +: LINES_PER_GROUP] = '1;
    end
    return m;
  endfunction

  function automatic reg_sel_e decode_ofs(input logic [3:0] ofs);
    case (ofs)
      OFS_SET:  return SEL_SET;
      OFS_CLR:  return SEL_CLR;
      OFS_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;

  // cycles since reset, saturating, so the delay check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  a_r5_sync_two_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int unsigned LANES = GROUPS_PER_BANK
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic               clr_we_i,
  input  logic [BANK_DW-1:0] wdata_i,
  input  logic [BANK_DW-1:0] src_s_i,
  output logic [BANK_DW-1:0] en_o,
  output logic [BANK_DW-1:0] status_o
);

  localparam logic [BANK_DW-1:0] LIVE_MASK = lane_mask(LANES);

  logic [BANK_DW-1:0] en_q;
  logic [BANK_DW-1:0] wbits;

  assign wbits = wdata_i & LIVE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (set_we_i) begin
      en_q <= en_q | wbits;
    end else if (clr_we_i) begin
      en_q <= en_q & ~wbits;
    end
  end

  assign en_o     = en_q;
  assign status_o = src_s_i & en_q & LIVE_MASK;

  a_r2_set_bits_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_o & $past(wbits)) == $past(wbits)));

  a_r2_set_keeps_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((en_o & ~$past(wbits)) == ($past(en_o) & ~$past(wbits))));

  a_r3_clr_bits_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((en_o & $past(wbits)) == '0));

  a_r3_clr_keeps_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((en_o & ~$past(wbits)) == ($past(en_o) & ~$past(wbits))));

  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(en_o));

endmodule

// File: rtl/irqc_group_out.sv
module irqc_group_out
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 20
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] status_i,
  output logic [NUM_GROUPS-1:0]                 irq_o
);

  logic [NUM_GROUPS-1:0] any_active;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_or
    assign any_active[g] = |status_i[src_index(g, 0) +: LINES_PER_GROUP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= any_active;
  end

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 20,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_GROUPS*LINES_PER_GROUP-1:0] src_i,
  input  logic                                  wr_en_i,
  input  logic                                  rd_en_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [BANK_DW-1:0]                    wdata_i,
  output logic [BANK_DW-1:0]                    rdata_o,
  output logic [NUM_GROUPS-1:0]                 group_irq_o
);

  localparam int unsigned NUM_SRC    = NUM_GROUPS * LINES_PER_GROUP;
  localparam int unsigned NUM_BANKS  = banks_for(NUM_GROUPS);
  localparam int unsigned PAD_W      = NUM_BANKS * BANK_DW;
  localparam int unsigned BANK_IDX_W = ADDR_W - 4;
  localparam logic [BANK_IDX_W-1:0] LAST_BANK = BANK_IDX_W'(NUM_BANKS - 1);

  // synchronised sources
  logic [NUM_SRC-1:0] src_s;
  logic [PAD_W-1:0]   src_pad;

  irqc_sync #(.WIDTH(NUM_SRC)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_s)
  );

  assign src_pad = PAD_W'(src_s);

  // address decode
  logic [BANK_IDX_W-1:0] bank_idx;
  reg_sel_e              sel;
  logic                  bank_hit;
  logic                  reg_hit;

  assign bank_idx = addr_i[ADDR_W-1:4];
  assign sel      = decode_ofs(addr_i[3:0]);
  assign bank_hit = (bank_idx <= LAST_BANK);
  assign reg_hit  = bank_hit && (sel != SEL_NONE);

  // banks
  logic [PAD_W-1:0] en_all;
  logic [PAD_W-1:0] status_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_bank;
    assign sel_bank = wr_en_i && bank_hit && (bank_idx == BANK_IDX_W'(b));

    irqc_bank #(.LANES(lanes_in_bank(NUM_GROUPS, b))) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_we_i(sel_bank && (sel == SEL_SET)),
      .clr_we_i(sel_bank && (sel == SEL_CLR)),
      .wdata_i (wdata_i),
      .src_s_i (src_pad[b*BANK_DW +: BANK_DW]),
      .en_o    (en_all[b*BANK_DW +: BANK_DW]),
      .status_o(status_all[b*BANK_DW +: BANK_DW])
    );
  end

  // read path
  logic [BANK_DW-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit && (bank_idx == BANK_IDX_W'(b))) begin
        case (sel)
          SEL_SET, SEL_CLR: rd_word = en_all[b*BANK_DW +: BANK_DW];
          SEL_STAT:         rd_word = status_all[b*BANK_DW +: BANK_DW];
          default:          rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en_i ? rd_word : '0;
  end

  // group outputs
  irqc_group_out #(.NUM_GROUPS(NUM_GROUPS)) i_group_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_all[NUM_SRC-1:0]),
    .irq_o   (group_irq_o)
  );

  // assertions
  logic ignored_wr;
  assign ignored_wr = wr_en_i && !(bank_hit && ((sel == SEL_SET) || (sel == SEL_CLR)));

  a_r7_ignored_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignored_wr |=> $stable(en_all));

  a_r7_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !reg_hit) |=> (rdata_o == '0));

  a_r8_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    a_r6_masked_group_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(en_all[src_index(g, 0) +: LINES_PER_GROUP]) == '0) |-> !group_irq_o[g]);

    a_r6_needs_live_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(group_irq_o[g]) |-> ($past(src_s[src_index(g, 0) +: LINES_PER_GROUP]) != '0));
  end

endmodule

// File: tb/test_irq_group_combiner.sv
module test_irq_group_combiner;

  localparam int NG   = 20;
  localparam int NS   = NG * 8;
  localparam int NB   = (NG + 3) / 4;
  localparam int PER  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NG-1:0] girq;

  int checks = 0;
  int errors = 0;

  logic [NS-1:0] en_m = '0;

  always #(PER/2) clk = ~clk;

  irq_group_combiner #(.NUM_GROUPS(NG), .ADDR_W(8)) i_irq_group_combiner (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .group_irq_o(girq)
  );

  function automatic logic [31:0] exp_status(input int bank);
    logic [31:0] w;
    w = '0;
    for (int lane = 0; lane < 4; lane++) begin
      int g;
      g = bank * 4 + lane;
      if (g < NG) w[lane*8 +: 8] = src[g*8 +: 8] & en_m[g*8 +: 8];
    end
    return w;
  endfunction

  function automatic logic [31:0] exp_enable(input int bank);
    logic [31:0] w;
    w = '0;
    for (int lane = 0; lane < 4; lane++) begin
      int g;
      g = bank * 4 + lane;
      if (g < NG) w[lane*8 +: 8] = en_m[g*8 +: 8];
    end
    return w;
  endfunction

  function automatic logic [NG-1:0] exp_groups();
    logic [NG-1:0] v;
    for (int g = 0; g < NG; g++) v[g] = |(src[g*8 +: 8] & en_m[g*8 +: 8]);
    return v;
  endfunction

  task automatic check(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int bank;
    bank = int'(a[7:4]);
    if (bank < NB && (a[3:0] == 4'h0 || a[3:0] == 4'h4)) begin
      for (int lane = 0; lane < 4; lane++) begin
        int g;
        g = bank * 4 + lane;
        if (g < NG) begin
          if (a[3:0] == 4'h0) en_m[g*8 +: 8] = en_m[g*8 +: 8] | d[lane*8 +: 8];
          else                en_m[g*8 +: 8] = en_m[g*8 +: 8] & ~d[lane*8 +: 8];
        end
      end
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      do_read(8'(b * 16 + 12), d);
      check({tag, " R5 status"}, 160'(d), 160'(exp_status(b)));
      do_read(8'(b * 16 + ((b % 2) ? 4 : 0)), d);
      check({tag, " R4 enable"}, 160'(d), 160'(exp_enable(b)));
    end
    check({tag, " R6 groups"}, 160'(girq), 160'(exp_groups()));
  endtask

  initial begin
    #(200000 * PER);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    src = '1;
    wait_cycles(3);
    // R1: reset state
    check("R1 rdata", 160'(rdata), 160'(0));
    check("R1 groups", 160'(girq), 160'(0));
    @(negedge clk) rst_n = 1'b1;
    wait_cycles(4);
    check("R1 groups after release", 160'(girq), 160'(0));
    for (int b = 0; b < NB; b++) begin
      do_read(8'(b * 16), d);
      check("R1 enables zero", 160'(d), 160'(0));
    end

    // R2 / R3: set and clear leave other bits alone
    do_write(8'h10, 32'h0000_A5F0);
    do_read(8'h10, d);
    check("R2 set", 160'(d), 160'(32'h0000_A5F0));
    do_write(8'h10, 32'h0300_0000);
    do_read(8'h14, d);
    check("R2 set keeps", 160'(d), 160'(32'h0300_A5F0));
    do_write(8'h14, 32'h0100_8030);
    do_read(8'h10, d);
    check("R3 clear", 160'(d), 160'(32'h0200_25C0));
    do_write(8'h14, 32'h0000_0000);
    do_read(8'h14, d);
    check("R3 zero clear no effect", 160'(d), 160'(32'h0200_25C0));

    // R7: ignored writes and unmapped reads
    do_write(8'h1C, 32'hFFFF_FFFF);
    do_write(8'h18, 32'hFFFF_FFFF);
    do_write(8'h50, 32'hFFFF_FFFF);
    do_write(8'hF0, 32'hFFFF_FFFF);
    do_write(8'h12, 32'hFFFF_FFFF);
    do_read(8'h10, d);
    check("R7 ignored writes bank1", 160'(d), 160'(32'h0200_25C0));
    do_read(8'h00, d);
    check("R7 ignored writes bank0", 160'(d), 160'(0));
    do_read(8'h18, d);
    check("R7 read 0x8", 160'(d), 160'(0));
    do_read(8'h5C, d);
    check("R7 read out of range", 160'(d), 160'(0));

    // R8: rdata drops to zero after a read
    do_read(8'h10, d);
    @(negedge clk);
    check("R8 idle zero", 160'(rdata), 160'(0));

    // R5 / R6: source 43 = group 5 line 3 -> bank 1 bit 11; latency
    do_write(8'h14, 32'hFFFF_FFFF);
    do_write(8'h10, 32'h0000_0800);
    @(negedge clk) src = '0;
    wait_cycles(4);
    check("R6 all low", 160'(girq), 160'(0));
    src[43] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 not before third edge", 160'(girq[5]), 160'(0));
    @(negedge clk);
    check("R6 third edge", 160'(girq), 160'(20'h00020));
    do_read(8'h1C, d);
    check("R5 lane mapping", 160'(d), 160'(32'h0000_0800));
    // enable change reaches output one edge after write edge
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h14; wdata = 32'h0000_0800;
    @(negedge clk);
    wr_en = 1'b0; model_write(8'h14, 32'h0000_0800);
    check("R6 before enable effect", 160'(girq[5]), 160'(1));
    @(negedge clk);
    check("R6 after clear", 160'(girq), 160'(0));

    // random phase
    for (int it = 0; it < 60; it++) begin
      for (int k = 0; k < NS / 32; k++) src[k*32 +: 32] = $urandom();
      for (int w = 0; w < 3; w++) begin
        logic [7:0] a;
        a = {4'($urandom_range(0, NB)), ($urandom_range(0, 3) == 0) ? 4'h4 :
             ($urandom_range(0, 5) == 0) ? 4'hC : 4'h0};
        do_write(a, $urandom() & $urandom());
      end
      wait_cycles(3);
      check_all("rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule